// File: doc/BRIEF.md
# Associative Compare-and-Write Word Array

The block is a bank of equal-width storage words in which every word carries its own comparator. A command broadcasts one mask and one data value to all words at once. On a compare, each word tests its selected bit positions against the broadcast value and reports a single match bit. The match bits land in a per-word tag register, where they can replace the tags or be merged with the earlier ones. A later write then puts the broadcast value into the selected bit positions of only the tagged words. A chain of compare and write commands can evaluate any truth table across every word in parallel, and no data ever leaves the array.

Two data movement commands rearrange the contents. A row shift moves the bits inside every word by one position. A column move copies the selected bit positions from each word into the word after it. A host port loads one word by index and reads one word by index, and the full tag vector is always visible. The array width and depth are parameters. The full size is 160-bit words and 512 words.

Top module: `assoc_array`

## Requirements
- R1: After a cycle with rst_n low at a clock edge, every word reads as zero and every tag is zero.
- R2: A compare (cmd_op = 1) computes, for each word, a match that is 1 exactly when every bit set in cmd_mask equals the same bit of cmd_data. Bits clear in cmd_mask are ignored, so an all-zero mask matches every word.
- R3: cmd_mode picks how a compare updates the tags: 0 loads the match, 1 ANDs the match into the old tag, 2 ORs it in, and 3 loads the inverted match.
- R4: A write (cmd_op = 2) sets, in each word whose tag is 1, the bits selected by cmd_mask to the matching bits of cmd_data. All other bits are kept, and untagged words do not change.
- R5: A left shift (cmd_op = 3) moves every word one bit toward its MSB, and a zero enters bit 0.
- R6: A right shift (cmd_op = 4) moves every word one bit toward its LSB, and a zero enters the MSB.
- R7: A column move (cmd_op = 5) copies the masked bits of word i into word i+1 for every i at once. Word 0 gets zeros in its masked bits, and unmasked bits stay as they were.
- R8: With host_wr_en high, word host_idx takes host_wdata at the next clock edge. host_rdata shows word host_idx without any register delay.
- R9: cmd_ready is low while host_wr_en is high. A command offered in that cycle is dropped and changes neither the words nor the tags.
- R10: An accepted command takes effect at the next clock edge. The result shows on tag_vec and host_rdata in that cycle, and a new command can be taken every cycle. Opcode 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | A command can be accepted this cycle |
| cmd_op | input | 3 | Opcode: 0 none, 1 compare, 2 write, 3 shift left, 4 shift right, 5 column move |
| cmd_mode | input | 2 | How a compare updates the tags |
| cmd_mask | input | WORD_W | Selects the bit positions that take part |
| cmd_data | input | WORD_W | Value to compare against, or value to write |
| host_wr_en | input | 1 | Host word write |
| host_idx | input | IDX_W | Word index for a host read or write |
| host_wdata | input | WORD_W | Data for a host write |
| host_rdata | output | WORD_W | Word selected by host_idx |
| tag_vec | output | DEPTH | Tag of every word, bit i for word i |

## Verification
The bench builds the array with 16-bit words and a depth of 8. At that size it can read back every word and the whole tag vector after each command and compare them with a model of all words. The depth is enough to show word 0 receiving zeros and a carry chain through several words on a column move. The word width is enough for masks that cover split, partial and empty fields, and for shifts that push bits out at both ends.

// File: rtl/assoc_pkg.sv
// Shared encodings for the associative word array.
// Assumes: opcode and tag-mode codes match the port descriptions of the top.
package assoc_pkg;
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_CMP = 3'd1,
        OP_WR  = 3'd2,
        OP_SHL = 3'd3,
        OP_SHR = 3'd4,
        OP_CMV = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        TG_LOAD = 2'd0,
        TG_AND  = 2'd1,
        TG_OR   = 2'd2,
        TG_INV  = 2'd3
    } tmode_e;
endpackage

// File: rtl/assoc_cell.sv
// One storage word that has its own masked comparator.
// Does: holds the word, reports a match against the broadcast value,
//       and applies a tagged write, a shift or a column move.
// Assumes: op is OP_NOP unless the top accepted a command, and host_we
//          never coincides with an accepted command.
module assoc_cell
    import assoc_pkg::*;
#(
    parameter int WORD_W = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [WORD_W-1:0] mask,
    input  logic [WORD_W-1:0] data,
    input  logic              tag,
    input  logic [WORD_W-1:0] prev_word,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] word_q,
    output logic              match
);
    // Masked equality: differing bits outside the mask do not count.
    always_comb match = ~|((word_q ^ data) & mask);

    // Word update: host load first, then the broadcast operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (host_we) begin
            word_q <= host_wdata;
        end else begin
            case (op)
                OP_WR:   if (tag) word_q <= (word_q & ~mask) | (data & mask);
                OP_SHL:  word_q <= word_q << 1;
                OP_SHR:  word_q <= word_q >> 1;
                OP_CMV:  word_q <= (word_q & ~mask) | (prev_word & mask);
                default: ;
            endcase
        end
    end

    // R4
    wr_untagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR && !tag && !host_we) |=> $stable(word_q));

    // R8
    host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> (word_q == $past(host_wdata)));
endmodule

// File: rtl/assoc_tags.sv
// Tag register with one bit per word.
// Does: merges the vector of per-word matches into the tags when a compare is accepted.
// Assumes: cmp_go is high only for an accepted compare command.
module assoc_tags
    import assoc_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_go,
    input  tmode_e           mode,
    input  logic [DEPTH-1:0] match,
    output logic [DEPTH-1:0] tags
);
    // Tag update using the combine mode selected for this compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags <= '0;
        end else if (cmp_go) begin
            case (mode)
                TG_LOAD: tags <= match;
                TG_AND:  tags <= tags & match;
                TG_OR:   tags <= tags | match;
                default: tags <= ~match;
            endcase
        end
    end

    // R3
    and_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && mode == TG_AND) |=> ((tags & ~$past(tags)) == '0));

    // R3
    or_never_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && mode == TG_OR) |=> ((~tags & $past(tags)) == '0));
endmodule

// File: rtl/assoc_array.sv
// Top of the associative word array.
// Does: accepts one broadcast command per cycle, builds one assoc_cell per
//       word, chains neighbouring words for the column move, and provides
//       host access by index.
// Assumes: a host write has priority over a command (cmd_ready drops).
module assoc_array
    import assoc_pkg::*;
#(
    parameter int WORD_W = 160,
    parameter int DEPTH  = 512,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [1:0]        cmd_mode,
    input  logic [WORD_W-1:0] cmd_mask,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              host_wr_en,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic [DEPTH-1:0]  tag_vec
);
    logic              fire;
    op_e               go_op;
    logic [WORD_W-1:0] word_arr [DEPTH];
    logic [WORD_W-1:0] prev_arr [DEPTH];
    logic [DEPTH-1:0]  match_vec;

    // Handshake: the host port blocks commands for the cycle it writes.
    always_comb cmd_ready = !host_wr_en;
    always_comb fire      = cmd_valid && cmd_ready;
    always_comb go_op     = fire ? op_e'(cmd_op) : OP_NOP;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_word
            if (i == 0) begin : g_head
                assign prev_arr[i] = '0;
            end else begin : g_link
                assign prev_arr[i] = word_arr[i-1];
            end

            assoc_cell #(.WORD_W(WORD_W)) u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .op         (go_op),
                .mask       (cmd_mask),
                .data       (cmd_data),
                .tag        (tag_vec[i]),
                .prev_word  (prev_arr[i]),
                .host_we    (host_wr_en && (host_idx == IDX_W'(i))),
                .host_wdata (host_wdata),
                .word_q     (word_arr[i]),
                .match      (match_vec[i])
            );
        end
    endgenerate

    assoc_tags #(.DEPTH(DEPTH)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_go (go_op == OP_CMP),
        .mode   (tmode_e'(cmd_mode)),
        .match  (match_vec),
        .tags   (tag_vec)
    );

    // Host read port: word picked by index, out-of-range reads give zero.
    always_comb host_rdata = (32'(host_idx) < DEPTH) ? word_arr[host_idx] : '0;

    // R2
    zero_mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 3'd1 && cmd_mode == 2'd0 && cmd_mask == '0) |=> (&tag_vec));

    // R7
    head_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 3'd5) |=> ((word_arr[0] & $past(cmd_mask)) == '0));

    // R5
    shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 3'd3) |=> (word_arr[0][0] == 1'b0));

    // R9
    drop_keeps_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> $stable(tag_vec));
endmodule

// File: tb/assoc_array_bench.sv
// Scoreboard bench: the driver updates a model of the array and queues the
// expected words and tags, and the monitor pops the queue and compares them.
module assoc_array_bench;
    localparam int W     = 16;
    localparam int D     = 8;
    localparam int IW    = 3;
    localparam int CLK_P = 10;

    typedef struct {
        string        req;
        bit           is_tag;
        int           idx;
        logic [W-1:0] exp_w;
        logic [D-1:0] exp_t;
    } item_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          cmd_valid = 0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = 0;
    logic [1:0]    cmd_mode = 0;
    logic [W-1:0]  cmd_mask = 0;
    logic [W-1:0]  cmd_data = 0;
    logic          host_wr_en = 0;
    logic [IW-1:0] drv_idx = 0;
    logic [IW-1:0] mon_idx = 0;
    logic [IW-1:0] host_idx;
    logic [W-1:0]  host_wdata = 0;
    logic [W-1:0]  host_rdata;
    logic [D-1:0]  tag_vec;

    item_t         sb_q[$];
    int            pending = 0;
    int            total = 0;
    int            bad = 0;
    bit            finished = 0;
    logic [W-1:0]  m_mem [D];
    logic [D-1:0]  m_tag;

    assign host_idx = host_wr_en ? drv_idx : mon_idx;

    always #(CLK_P/2) clk = ~clk;

    assoc_array #(.WORD_W(W), .DEPTH(D)) u_assoc_array (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_mode(cmd_mode), .cmd_mask(cmd_mask),
        .cmd_data(cmd_data), .host_wr_en(host_wr_en), .host_idx(host_idx),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .tag_vec(tag_vec)
    );

    // Queue the whole model state under the tag of one requirement.
    task automatic push_all(input string req);
        for (int i = 0; i < D; i++) begin
            sb_q.push_back('{req, 1'b0, i, m_mem[i], '0});
            pending++;
        end
        sb_q.push_back('{req, 1'b1, 0, '0, m_tag});
        pending++;
    endtask

    // Wait until the monitor has compared everything in the queue.
    task automatic drain();
        while (pending != 0) @(posedge clk);
    endtask

    // Apply a model update that follows the requirements, not the RTL.
    task automatic model_cmd(input int op, input int mode,
                             input logic [W-1:0] mask, input logic [W-1:0] data);
        logic [W-1:0] old_mem [D];
        logic [D-1:0] mt;
        for (int i = 0; i < D; i++) old_mem[i] = m_mem[i];
        for (int i = 0; i < D; i++) mt[i] = (((old_mem[i] ^ data) & mask) == '0);
        case (op)
            1: case (mode)
                   0: m_tag = mt;
                   1: m_tag = m_tag & mt;
                   2: m_tag = m_tag | mt;
                   default: m_tag = ~mt;
               endcase
            2: for (int i = 0; i < D; i++)
                   if (m_tag[i]) m_mem[i] = (old_mem[i] & ~mask) | (data & mask);
            3: for (int i = 0; i < D; i++) m_mem[i] = {old_mem[i][W-2:0], 1'b0};
            4: for (int i = 0; i < D; i++) m_mem[i] = {1'b0, old_mem[i][W-1:1]};
            5: for (int i = 0; i < D; i++)
                   m_mem[i] = (old_mem[i] & ~mask) | (((i == 0) ? '0 : old_mem[i-1]) & mask);
            default: ;
        endcase
    endtask

    // Driver: one accepted command, then model update and expectations.
    task automatic do_cmd(input string req, input int op, input int mode,
                          input logic [W-1:0] mask, input logic [W-1:0] data);
        @(posedge clk); #1;
        cmd_valid = 1; cmd_op = op[2:0]; cmd_mode = mode[1:0];
        cmd_mask = mask; cmd_data = data;
        @(posedge clk); #1;
        cmd_valid = 0; cmd_op = 0;
        model_cmd(op, mode, mask, data);
        push_all(req);
        drain();
    endtask

    // Driver: host load of one word.
    task automatic host_write(input int idx, input logic [W-1:0] val);
        @(posedge clk); #1;
        host_wr_en = 1; drv_idx = idx[IW-1:0]; host_wdata = val;
        @(posedge clk); #1;
        host_wr_en = 0;
        m_mem[idx] = val;
    endtask

    // Monitor: pops expected items at the falling edge and compares them.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                total++;
                if (it.is_tag) begin
                    if (tag_vec !== it.exp_t) begin
                        bad++;
                        $display("FAIL %s tags: actual=%h expected=%h", it.req, tag_vec, it.exp_t);
                    end
                end else begin
                    mon_idx = it.idx[IW-1:0];
                    #1;
                    if (host_rdata !== it.exp_w) begin
                        bad++;
                        $display("FAIL %s word %0d: actual=%h expected=%h",
                                 it.req, it.idx, host_rdata, it.exp_w);
                    end
                end
                pending--;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        for (int i = 0; i < D; i++) m_mem[i] = '0;
        m_tag = '0;
        host_wr_en = 1; drv_idx = 3; host_wdata = 16'hFFFF;
        cmd_valid = 1; cmd_op = 3'd3;
        repeat (3) @(posedge clk);
        #1;
        host_wr_en = 0; cmd_valid = 0; cmd_op = 0;
        rst_n = 1;
        // R1: reset state
        push_all("R1");
        drain();

        // R8: host loads, read back by index
        for (int i = 0; i < D; i++)
            host_write(i, {8'(i * 3), 8'(8'h50 + i)});
        push_all("R8");
        drain();

        // R2: masked compare on the low byte picks word 2 only
        do_cmd("R2", 1, 0, 16'h00FF, 16'hAB52);
        // R2: an empty mask matches every word
        do_cmd("R2", 1, 0, 16'h0000, 16'h1234);
        // R3: AND keeps only even low bytes
        do_cmd("R3", 1, 1, 16'h0001, 16'h0000);
        // R3: OR adds word 5 through its high byte
        do_cmd("R3", 1, 2, 16'hFF00, 16'h0F00);
        // R4: write the top nibble of the tagged words
        do_cmd("R4", 2, 0, 16'hF000, 16'h9000);
        // R3: inverted load of a two-bit match
        do_cmd("R3", 1, 3, 16'h0003, 16'h0001);
        // R4: a write with a split mask
        do_cmd("R4", 2, 0, 16'h0F0F, 16'hA5C3);
        // R5: shift left
        do_cmd("R5", 3, 0, 16'h0000, 16'h0000);
        // R6: shift right, twice
        do_cmd("R6", 4, 0, 16'h0000, 16'h0000);
        do_cmd("R6", 4, 0, 16'h0000, 16'h0000);
        // R7: column move on a split mask
        do_cmd("R7", 5, 0, 16'hF0F0, 16'h0000);
        // R7: column move over the whole word
        do_cmd("R7", 5, 0, 16'hFFFF, 16'h0000);
        // R10: opcode 0 changes nothing
        do_cmd("R10", 0, 0, 16'hFFFF, 16'hFFFF);

        // R10: two accepted commands on consecutive cycles
        host_write(1, 16'h1234);
        host_write(4, 16'h8001);
        @(posedge clk); #1;
        cmd_valid = 1; cmd_op = 3'd1; cmd_mode = 2'd0;
        cmd_mask = 16'hFFFF; cmd_data = 16'h1234;
        @(posedge clk); #1;
        model_cmd(1, 0, 16'hFFFF, 16'h1234);
        cmd_op = 3'd2; cmd_mask = 16'h00FF; cmd_data = 16'h0077;
        @(posedge clk); #1;
        cmd_valid = 0; cmd_op = 0;
        model_cmd(2, 0, 16'h00FF, 16'h0077);
        push_all("R10");
        drain();

        // R9: a command offered during a host write is dropped
        @(posedge clk); #1;
        host_wr_en = 1; drv_idx = 6; host_wdata = 16'h0F0F;
        cmd_valid = 1; cmd_op = 3'd1; cmd_mode = 2'd0;
        cmd_mask = 16'h0000; cmd_data = 16'h0000;
        #1;
        total++;
        if (cmd_ready !== 1'b0) begin
            bad++;
            $display("FAIL R9 cmd_ready: actual=%b expected=0", cmd_ready);
        end
        @(posedge clk); #1;
        host_wr_en = 0; cmd_valid = 0; cmd_op = 0;
        m_mem[6] = 16'h0F0F;
        push_all("R9");
        drain();

        // R9: cmd_ready returns once the host write ends
        total++;
        if (cmd_ready !== 1'b1) begin
            bad++;
            $display("FAIL R9 cmd_ready: actual=%b expected=1", cmd_ready);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule